// File: doc/BRIEF.md
# UART Register File with Divisor Banking

This block is the host-facing register file of a 16450/16550-style serial port. A simple byte bus with a 3-bit offset, a read strobe, a write strobe and write data reaches eight register offsets. Bit 7 of the line-control register banks the first two offsets. When it is set, they reach the low and high bytes of the baud divisor in place of the data port and the interrupt-enable register.

Several accesses have side effects, and the block carries them out. A write to the data port pushes into the transmit FIFO, or overwrites the newest slot when that FIFO is full. A read of the data port pops the receive FIFO. Writes to FIFO control can flush either FIFO, and a change of FIFO mode flushes both. Reads of line status and modem status clear their sticky bits. The block keeps only the occupancy and pointers of the two FIFOs. Their storage, the serial shifters and the interrupt prioritiser sit outside the block. The block exchanges push and pop strobes with them, takes status events in, and drives the stored configuration out.

Top module: `uart_regbank`

## Requirements
- R1: After reset, line control reads 0x03 and every other stored register reads 0. The divisor is 0, both FIFO counts are 0, FIFO mode is off and `thre_pending` is 1.
- R2: While line-control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. Such accesses cause no FIFO push or pop and leave the interrupt-enable register unchanged.
- R3: A write to offset 0 with bank bit 0 asserts `tx_push` when the transmit count is below the current depth. The count and the write pointer then advance. When the count equals the depth, the write asserts `tx_overwrite` instead, and count and pointer stay unchanged.
- R4: A data-port write clears line-status bits 6 (transmitter idle) and 5 (holding empty), and clears `thre_pending`.
- R5: A write to offset 2 stores the value masked with 0xC1. If bit 0 differs from the current FIFO mode, both FIFOs flush. Bit 1 flushes the receive FIFO and bit 2 flushes the transmit FIFO. The depth is 16 with bit 0 set and 1 with it clear.
- R6: A receive flush zeroes its count and pointers and clears line-status bit 0 (data ready). A transmit flush zeroes its count and pointers and clears line-status bit 5.
- R7: A read of offset 0 with bank bit 0 returns `rx_head`. If the receive count is nonzero, the read asserts `rx_pop`. Bit 0 then shows whether entries remain, and `timeout_clr` pulses.
- R8: A read of offset 2 returns 0xC0 OR `irq_code`. If interrupt-enable bit 1 is set, the read also clears `thre_pending`.
- R9: A read of offset 5 returns line status and then clears bits 1, 2, 3, 4 and 7. A read of offset 6 returns modem status and then clears all of it.
- R10: Offset 4 reads 0 while `modem_ctrl` holds the written value masked with 0x1F. Interrupt enable keeps bits 3:0. Offset 7 is a plain read/write byte.
- R11: Writes to offsets 5 and 6 have no effect.
- R12: The status inputs set bits:
  - `ser_err_set` bits 0 to 3 set line-status bits 1 to 4 (overrun, parity, framing, break), and any of them sets bit 7.
  - `thr_empty_set` sets bit 5 and `tx_idle_set` sets bit 6.
  - `rx_push` sets bit 0.
  - `tx_pull` sets `thre_pending` and pops the transmit count.
  - `msr_set` is ORed into modem status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle, 0 otherwise |
| rx_head | input | 8 | Oldest byte of the external receive storage |
| rx_push | input | 1 | Receiver delivers a byte |
| rx_pop | output | 1 | Remove the oldest receive byte |
| rx_fifo_clr | output | 1 | Receive FIFO flush |
| rx_count | output | 5 | Receive occupancy |
| rx_wr_ptr | output | 4 | Receive write index |
| rx_rd_ptr | output | 4 | Receive read index |
| tx_push | output | 1 | Store `tx_byte` at `tx_wr_ptr` and advance |
| tx_overwrite | output | 1 | Replace the newest transmit byte |
| tx_byte | output | 8 | Byte for the transmit storage |
| tx_pull | input | 1 | Transmitter takes a byte |
| tx_fifo_clr | output | 1 | Transmit FIFO flush |
| tx_count | output | 5 | Transmit occupancy |
| tx_wr_ptr | output | 4 | Transmit write index |
| tx_rd_ptr | output | 4 | Transmit read index |
| ser_err_set | input | 4 | Overrun, parity, framing and break events |
| thr_empty_set | input | 1 | Holding register became empty |
| tx_idle_set | input | 1 | Shifter became idle |
| msr_set | input | 8 | Modem status events |
| irq_code | input | 4 | Code from the interrupt prioritiser |
| timeout_clr | output | 1 | Restart the character-timeout counter |
| thre_pending | output | 1 | Pending holding-empty interrupt flag |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line control |
| int_enable | output | 4 | Interrupt enable |
| fifo_ctrl | output | 8 | Stored FIFO control |
| fifo_mode | output | 1 | FIFOs enabled |
| modem_ctrl | output | 5 | Modem control |

## Verification
Data-port writes are issued in three situations: with the transmit FIFO below depth, at depth in single-byte mode, and at depth after sixteen pushes in FIFO mode. This separates a push from an overwrite, and it exposes pointer wrap at the depth boundary. The same offsets 0 and 1 are accessed with the bank bit set and with it clear, which shows whether a divisor access leaks into the FIFOs. FIFO-control writes are tried three ways: with a mode change, with only the receive-reset bit, and with only the transmit-reset bit. These tell a mode-change flush apart from a selective one. Status reads are repeated back to back, so the first read shows the set bits and the second shows which of them clear on read.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_IIR  = 3'd2;
  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_MCR  = 3'd4;
  localparam logic [2:0] OFS_LSR  = 3'd5;
  localparam logic [2:0] OFS_MSR  = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  localparam logic [7:0] FCR_KEEP   = 8'hC1;
  localparam logic [4:0] MCR_KEEP   = 5'h1F;
  localparam logic [7:0] LCR_INIT   = 8'h03;
  localparam logic [7:0] LSR_STICKY = 8'h9E;

  localparam int LCR_BANK  = 7;
  localparam int FCR_EN    = 0;
  localparam int FCR_RXRST = 1;
  localparam int FCR_TXRST = 2;
  localparam int IER_THRE  = 1;
  localparam int LSR_DR    = 0;
  localparam int LSR_ERRS  = 7;
  localparam int LSR_THRE  = 5;
  localparam int LSR_IDLE  = 6;

  typedef struct packed {
    logic wr_thr, wr_dll, wr_dlm, wr_ier, wr_fcr, wr_lcr, wr_mcr, wr_scr;
    logic rd_rbr, rd_iir, rd_lsr, rd_msr;
  } rb_strobe_t;

  function automatic logic [7:0] lsr_after_read(input logic [7:0] v);
    return v & ~LSR_STICKY;
  endfunction

  function automatic logic [7:0] iir_view(input logic [3:0] code);
    return {2'b11, 2'b00, code};
  endfunction
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
(
  input  logic [2:0] addr,
  input  logic       rd,
  input  logic       wr,
  input  logic       bank,
  output rb_strobe_t st
);
  always_comb begin
    st = '0;
    st.wr_thr = wr & !bank & (addr == OFS_DATA);
    st.wr_dll = wr &  bank & (addr == OFS_DATA);
    st.wr_dlm = wr &  bank & (addr == OFS_IER);
    st.wr_ier = wr & !bank & (addr == OFS_IER);
    st.wr_fcr = wr & (addr == OFS_IIR);
    st.wr_lcr = wr & (addr == OFS_LCR);
    st.wr_mcr = wr & (addr == OFS_MCR);
    st.wr_scr = wr & (addr == OFS_SCR);
    st.rd_rbr = rd & !bank & (addr == OFS_DATA);
    st.rd_iir = rd & (addr == OFS_IIR);
    st.rd_lsr = rd & (addr == OFS_LSR);
    st.rd_msr = rd & (addr == OFS_MSR);
  end
endmodule

// File: rtl/uart_rb_fifo_track.sv
module uart_rb_fifo_track #(
  parameter int MAX_DEPTH = 16,
  localparam int PTR_W = $clog2(MAX_DEPTH),
  localparam int CNT_W = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             big,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] count,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr
);
  logic [CNT_W-1:0] depth;
  logic push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p, input logic b);
    if (!b) return '0;
    return (32'(p) == MAX_DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign depth   = big ? CNT_W'(MAX_DEPTH) : CNT_W'(1);
  assign push_ok = push & (count < depth);
  assign pop_ok  = pop & (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0; wr_ptr <= '0; rd_ptr <= '0;
    end else if (flush) begin
      count <= '0; wr_ptr <= '0; rd_ptr <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr, big);
      if (pop_ok)  rd_ptr <= step(rd_ptr, big);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= depth);
  p_flush_zeroes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && wr_ptr == '0 && rd_ptr == '0));
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int MAX_DEPTH = 16,
  localparam int PTR_W = $clog2(MAX_DEPTH),
  localparam int CNT_W = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [7:0]       rx_head,
  input  logic             rx_push,
  output logic             rx_pop,
  output logic             rx_fifo_clr,
  output logic [CNT_W-1:0] rx_count,
  output logic [PTR_W-1:0] rx_wr_ptr,
  output logic [PTR_W-1:0] rx_rd_ptr,
  output logic             tx_push,
  output logic             tx_overwrite,
  output logic [7:0]       tx_byte,
  input  logic             tx_pull,
  output logic             tx_fifo_clr,
  output logic [CNT_W-1:0] tx_count,
  output logic [PTR_W-1:0] tx_wr_ptr,
  output logic [PTR_W-1:0] tx_rd_ptr,
  input  logic [3:0]       ser_err_set,
  input  logic             thr_empty_set,
  input  logic             tx_idle_set,
  input  logic [7:0]       msr_set,
  input  logic [3:0]       irq_code,
  output logic             timeout_clr,
  output logic             thre_pending,
  output logic [15:0]      divisor,
  output logic [7:0]       line_ctrl,
  output logic [3:0]       int_enable,
  output logic [7:0]       fifo_ctrl,
  output logic             fifo_mode,
  output logic [4:0]       modem_ctrl
);
  rb_strobe_t st;
  logic [7:0] dll_q, dlm_q, lcr_q, scr_q, fcr_q, lsr_q, msr_q;
  logic [7:0] lsr_d, msr_d;
  logic [3:0] ier_q;
  logic [4:0] mcr_q;
  logic       mode_q, thre_q, thre_d;
  logic       mode_flip, tx_full;
  logic [CNT_W-1:0] tx_depth;

  uart_rb_decode u_decode (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .bank(lcr_q[LCR_BANK]), .st(st)
  );

  assign mode_flip   = st.wr_fcr & (bus_wdata[FCR_EN] != mode_q);
  assign rx_fifo_clr = st.wr_fcr & (bus_wdata[FCR_RXRST] | mode_flip);
  assign tx_fifo_clr = st.wr_fcr & (bus_wdata[FCR_TXRST] | mode_flip);

  assign tx_depth     = mode_q ? CNT_W'(MAX_DEPTH) : CNT_W'(1);
  assign tx_full      = (tx_count == tx_depth);
  assign tx_push      = st.wr_thr & !tx_full;
  assign tx_overwrite = st.wr_thr & tx_full;
  assign tx_byte      = bus_wdata;
  assign rx_pop       = st.rd_rbr & (rx_count != '0);
  assign timeout_clr  = st.rd_rbr;

  uart_rb_fifo_track #(.MAX_DEPTH(MAX_DEPTH)) u_rx_track (
    .clk(clk), .rst_n(rst_n), .flush(rx_fifo_clr), .big(mode_q),
    .push(rx_push), .pop(rx_pop),
    .count(rx_count), .wr_ptr(rx_wr_ptr), .rd_ptr(rx_rd_ptr)
  );

  uart_rb_fifo_track #(.MAX_DEPTH(MAX_DEPTH)) u_tx_track (
    .clk(clk), .rst_n(rst_n), .flush(tx_fifo_clr), .big(mode_q),
    .push(tx_push), .pop(tx_pull),
    .count(tx_count), .wr_ptr(tx_wr_ptr), .rd_ptr(tx_rd_ptr)
  );

  // Line status: clear-on-read first, new events win, data-port write wins over set.
  always_comb begin
    lsr_d = st.rd_lsr ? lsr_after_read(lsr_q) : lsr_q;
    lsr_d[4:1] = lsr_d[4:1] | ser_err_set;
    if (|ser_err_set)  lsr_d[LSR_ERRS] = 1'b1;
    if (thr_empty_set) lsr_d[LSR_THRE] = 1'b1;
    if (tx_idle_set)   lsr_d[LSR_IDLE] = 1'b1;
    if (st.wr_thr)     lsr_d[LSR_IDLE:LSR_THRE] = 2'b00;
    if (tx_fifo_clr)   lsr_d[LSR_THRE] = 1'b0;
    if (rx_fifo_clr)   lsr_d[LSR_DR] = 1'b0;
    else if (rx_push)  lsr_d[LSR_DR] = 1'b1;
    else if (st.rd_rbr) lsr_d[LSR_DR] = (rx_count > CNT_W'(1));
  end

  assign msr_d = (st.rd_msr ? 8'h00 : msr_q) | msr_set;

  always_comb begin
    thre_d = thre_q;
    if (st.wr_thr)                          thre_d = 1'b0;
    else if (st.rd_iir && ier_q[IER_THRE])  thre_d = 1'b0;
    else if (tx_pull)                       thre_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dll_q <= '0; dlm_q <= '0; ier_q <= '0; lcr_q <= LCR_INIT; mcr_q <= '0;
      scr_q <= '0; fcr_q <= '0; mode_q <= 1'b0; lsr_q <= '0; msr_q <= '0;
      thre_q <= 1'b1;
    end else begin
      if (st.wr_dll) dll_q <= bus_wdata;
      if (st.wr_dlm) dlm_q <= bus_wdata;
      if (st.wr_ier) ier_q <= bus_wdata[3:0];
      if (st.wr_lcr) lcr_q <= bus_wdata;
      if (st.wr_mcr) mcr_q <= bus_wdata[4:0] & MCR_KEEP;
      if (st.wr_scr) scr_q <= bus_wdata;
      if (st.wr_fcr) begin
        fcr_q  <= bus_wdata & FCR_KEEP;
        mode_q <= bus_wdata[FCR_EN];
      end
      lsr_q  <= lsr_d;
      msr_q  <= msr_d;
      thre_q <= thre_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_DATA: bus_rdata = lcr_q[LCR_BANK] ? dll_q : rx_head;
        OFS_IER:  bus_rdata = lcr_q[LCR_BANK] ? dlm_q : {4'b0, ier_q};
        OFS_IIR:  bus_rdata = iir_view(irq_code);
        OFS_LCR:  bus_rdata = lcr_q;
        OFS_MCR:  bus_rdata = 8'h00;
        OFS_LSR:  bus_rdata = lsr_q;
        OFS_MSR:  bus_rdata = msr_q;
        default:  bus_rdata = scr_q;
      endcase
    end
  end

  assign divisor      = {dlm_q, dll_q};
  assign line_ctrl    = lcr_q;
  assign int_enable   = ier_q;
  assign fifo_ctrl    = fcr_q;
  assign fifo_mode    = mode_q;
  assign modem_ctrl   = mcr_q;
  assign thre_pending = thre_q;

  p_push_or_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_push && tx_overwrite));
  p_overwrite_holds_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_overwrite && !tx_pull) |=> $stable(tx_count) && $stable(tx_wr_ptr));
  p_thr_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !lcr_q[LCR_BANK] && bus_addr == OFS_DATA) |=> (!thre_pending && lsr_q[6:5] == 2'b00));
  p_mode_change_flushes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_IIR && bus_wdata[0] != fifo_mode) |=> (rx_count == '0 && tx_count == '0));
  p_bank_no_fifo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_q[LCR_BANK] && (bus_rd || bus_wr) && bus_addr == OFS_DATA) |-> (!rx_pop && !tx_push && !tx_overwrite));
  p_lsr_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_LSR && ser_err_set == 4'h0) |=> (lsr_q[4:1] == 4'h0 && !lsr_q[7]));
  p_msr_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_MSR && msr_set == 8'h00) |=> (msr_q == 8'h00));
  p_mcr_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_MCR) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/uart_regbank_bench.sv
module uart_regbank_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata, rx_head = '0, tx_byte, line_ctrl, fifo_ctrl, msr_set = '0;
  logic rx_push = 1'b0, rx_pop, rx_fifo_clr, tx_push, tx_overwrite, tx_pull = 1'b0, tx_fifo_clr;
  logic [4:0] rx_count, tx_count, modem_ctrl;
  logic [3:0] rx_wr_ptr, rx_rd_ptr, tx_wr_ptr, tx_rd_ptr, int_enable;
  logic [3:0] ser_err_set = '0, irq_code = '0;
  logic thr_empty_set = 1'b0, tx_idle_set = 1'b0, timeout_clr, thre_pending, fifo_mode;
  logic [15:0] divisor;

  int checks = 0, failures = 0;
  logic seen_push, seen_ovw, seen_pop, seen_tclr;
  logic [7:0] rd_val;

  always #4 clk = ~clk;

  uart_regbank u_uart_regbank (.*);

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1 seen_push = tx_push; seen_ovw = tx_overwrite;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 rd_val = bus_rdata; seen_pop = rx_pop; seen_tclr = timeout_clr;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic pulse_rx(input logic [7:0] b);
    @(negedge clk); rx_head = b; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic pulse_pull;
    @(negedge clk); tx_pull = 1'b1;
    @(negedge clk); tx_pull = 1'b0;
  endtask

  task automatic t_reset;
    rd(3); chk("R1 lcr", rd_val, 8'h03);
    rd(1); chk("R1 ier", rd_val, 0);
    rd(5); chk("R1 lsr", rd_val, 0);
    rd(6); chk("R1 msr", rd_val, 0);
    rd(7); chk("R1 scr", rd_val, 0);
    rd(2); chk("R1 iir", rd_val, 8'hC0);
    chk("R1 thre_pending", thre_pending, 1);
    chk("R1 divisor", divisor, 0);
    chk("R1 counts", {rx_count, tx_count}, 0);
    chk("R1 fifo_mode", fifo_mode, 0);
  endtask

  task automatic t_bank;
    wr(3, 8'h83);
    wr(0, 8'h34); chk("R2 no push", {seen_push, seen_ovw}, 0);
    wr(1, 8'h12);
    chk("R2 divisor", divisor, 16'h1234);
    chk("R2 ier untouched", int_enable, 0);
    chk("R2 tx_count", tx_count, 0);
    rx_head = 8'hEE;
    rd(0); chk("R2 dll read", rd_val, 8'h34); chk("R2 no pop", seen_pop, 0);
    rd(1); chk("R2 dlm read", rd_val, 8'h12);
    wr(3, 8'h03);
    wr(1, 8'hFF); rd(1);
    chk("R10 ier masked", rd_val, 8'h0F); chk("R10 int_enable", int_enable, 4'hF);
    wr(1, 8'h00);
  endtask

  task automatic t_tx_single;
    wr(0, 8'h41); chk("R3 push below depth", {seen_push, seen_ovw}, 2'b10);
    chk("R3 count 1", tx_count, 1); chk("R3 ptr depth1", tx_wr_ptr, 0);
    wr(0, 8'h42); chk("R3 overwrite at depth", {seen_push, seen_ovw}, 2'b01);
    chk("R3 count held", tx_count, 1);
    @(negedge clk); thr_empty_set = 1'b1; tx_idle_set = 1'b1;
    @(negedge clk); thr_empty_set = 1'b0; tx_idle_set = 1'b0;
    rd(5); chk("R12 lsr bits 5 6", rd_val, 8'h60);
    wr(0, 8'h43);
    rd(5); chk("R4 lsr cleared by write", rd_val, 8'h00);
    chk("R4 thre cleared", thre_pending, 0);
    pulse_pull;
    chk("R12 pull sets thre", thre_pending, 1);
    chk("R12 pull pops", tx_count, 0);
  endtask

  task automatic t_tx_fifo;
    wr(0, 8'h01); chk("R3 pre count", tx_count, 1);
    wr(2, 8'hC7);
    chk("R5 fcr masked", fifo_ctrl, 8'hC1); chk("R5 mode on", fifo_mode, 1);
    chk("R5 flush on mode change", tx_count, 0);
    for (int i = 0; i < 15; i++) wr(0, 8'(i));
    chk("R3 ptr 15", tx_wr_ptr, 15);
    wr(0, 8'h7F); chk("R3 16th push", {seen_push, seen_ovw}, 2'b10);
    chk("R3 count 16", tx_count, 16); chk("R3 ptr wraps", tx_wr_ptr, 0);
    wr(0, 8'h80); chk("R3 17th overwrites", {seen_push, seen_ovw}, 2'b01);
    chk("R3 count stays 16", tx_count, 16);
    wr(2, 8'h05);
    chk("R6 tx flush", tx_count, 0); chk("R5 mode kept", fifo_mode, 1);
  endtask

  task automatic t_rx;
    pulse_rx(8'h5A); pulse_rx(8'h11); pulse_rx(8'h22);
    chk("R12 rx count", rx_count, 3);
    rd(5); chk("R12 data ready", rd_val, 8'h01);
    rx_head = 8'h5A;
    rd(0); chk("R7 head data", rd_val, 8'h5A);
    chk("R7 pop", seen_pop, 1); chk("R7 timeout_clr", seen_tclr, 1);
    chk("R7 count 2", rx_count, 2);
    rd(5); chk("R7 ready remains", rd_val, 8'h01);
    rd(0); rd(0);
    rd(5); chk("R7 ready drops", rd_val, 8'h00);
    rd(0); chk("R7 empty no pop", seen_pop, 0); chk("R7 count 0", rx_count, 0);
    pulse_rx(8'h01); pulse_rx(8'h02);
    wr(2, 8'hC3);
    chk("R6 rx flush", rx_count, 0); chk("R6 rx ptr", rx_wr_ptr, 0);
    rd(5); chk("R6 ready cleared", rd_val, 8'h00);
    pulse_rx(8'h03); wr(0, 8'h09);
    wr(2, 8'h00);
    chk("R5 toggle flushes both", {rx_count, tx_count}, 0);
    chk("R5 mode off", fifo_mode, 0);
  endtask

  task automatic t_status;
    @(negedge clk); ser_err_set = 4'hF;
    @(negedge clk); ser_err_set = 4'h0;
    rd(5); chk("R9 lsr errors", rd_val, 8'h9E);
    rd(5); chk("R9 lsr cleared", rd_val, 8'h00);
    @(negedge clk); msr_set = 8'hA5;
    @(negedge clk); msr_set = 8'h00;
    rd(6); chk("R9 msr", rd_val, 8'hA5);
    rd(6); chk("R9 msr cleared", rd_val, 8'h00);
    irq_code = 4'h6;
    rd(2); chk("R8 iir code", rd_val, 8'hC6);
    pulse_pull; chk("R8 pending set", thre_pending, 1);
    rd(2); chk("R8 kept without enable", thre_pending, 1);
    wr(1, 8'h02);
    rd(2); chk("R8 cleared with enable", thre_pending, 0);
  endtask

  task automatic t_misc;
    wr(5, 8'hFF); wr(6, 8'hFF);
    rd(5); chk("R11 lsr unwritten", rd_val, 8'h00);
    rd(6); chk("R11 msr unwritten", rd_val, 8'h00);
    wr(4, 8'hFF); chk("R10 modem_ctrl", modem_ctrl, 5'h1F);
    rd(4); chk("R10 mcr reads 0", rd_val, 8'h00);
    wr(7, 8'hA7); rd(7); chk("R10 scratch", rd_val, 8'hA7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_bank; t_tx_single; t_tx_fifo; t_rx; t_status; t_misc;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired got=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule